// File: doc/BRIEF.md
# Banked SRAM Channel with Write Forwarding and Light Sleep

The block is one memory channel built from a number of banks. Each bank holds 2048 words, and the number of banks is fixed when the block is built. The channel has one write port and one read port, and both run on a single clock. Each cycle the channel accepts one write and one read. Every read returns its word through a pipeline of fixed depth. The read-valid output is the read request delayed by that depth.

Two build-time options change how the channel behaves.

- **Write forwarding.** When a read and a write target the same address in the same cycle, the read returns the new write data. The write still lands in the array.
- **Light sleep.** Every bank rests asleep. A bank wakes one cycle before its access and goes back to sleep once the access is done. This adds exactly one cycle to the read latency. Each bank's sleep state is visible on an output so it can be checked.

Top module: `banked_sram_channel`

## Requirements
- R1: With light sleep off, a read request in cycle c gives `rd_valid_o` high, together with its data, in cycle c+12. `rd_valid_o` is low in every cycle that no request maps to.
- R2: With light sleep on, the same read returns in cycle c+13, with no other change to behaviour.
- R3: A read may be issued in every cycle. Back-to-back reads return in consecutive cycles, in issue order, each with its own word.
- R4: A write stores its data at the addressed word. A read issued in any later cycle, including the very next cycle, returns that data.
- R5: With forwarding on, a read and a write to the same address in the same cycle return the write data, with the normal latency. Later reads also return that data.
- R6: With forwarding off, such a same-cycle pair returns the word stored before the write. Later reads return the new data.
- R7: The address is {bank index, word index}. The word index is the low 11 bits and the bank index is the remaining upper bits. Equal word indices in different banks are separate storage.
- R8: A bank index at or above the number of enabled banks selects a disabled bank. A write there changes no enabled bank. A read there still gives `rd_valid_o` at the normal latency, and its data has no defined value.
- R9: With light sleep on, bit b of `bank_awake_o` is 1 exactly in the cycle after a cycle in which bank b was the target of a read or a write, and 0 otherwise. With light sleep off, every bit is 1.
- R10: Time spent asleep never alters stored words. Data written before a long idle period reads back unchanged.
- R11: While `rst_n` is low, `rd_valid_o` is 0 and, with light sleep on, all sleep flags read asleep. Reset drops reads that are in flight but keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write address {bank, word} |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address {bank, word} |
| rd_valid_o | output | 1 | Read data valid, the read request delayed by the latency |
| rd_data_o | output | DATA_W | Read data |
| bank_awake_o | output | NUM_BANKS | Per-bank awake flag, 1 = awake |

## Verification
The case that matters most is a read and a write landing on the same address in the same cycle, where forwarding and the ordinary array read compete for the result. The bench provokes it by driving both ports with one address and new data in a single cycle. It runs two builds side by side on the same stimulus:

- one with forwarding on and light sleep off, which must return the new word after 12 cycles;
- one with forwarding off and light sleep on, which must return the old word after 13 cycles.

A follow-up read must then see the new word in both builds. The same collision is also a cycle in which both ports wake banks at once, and the per-bank flags are compared in every cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Word index bits inside one bank; a bank holds 2**WORD_IDX_W words.
    localparam int unsigned WORD_IDX_W = 11;
    localparam int unsigned BANK_DEPTH = 1 << WORD_IDX_W;
    localparam int unsigned MAX_BANKS  = 42;
    localparam int unsigned MAX_DATA_W = 72;

    // Read latency is built from an array part and an output part.
    localparam int unsigned CORE_LAT = 10;
    localparam int unsigned TAIL_LAT = 2;
    localparam int unsigned WAKE_LAT = 1;

    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_AWAKE = 1'b1
    } pwr_state_e;

    function automatic int unsigned read_latency(bit low_power);
        return CORE_LAT + TAIL_LAT + (low_power ? WAKE_LAT : 0);
    endfunction

    function automatic int unsigned bank_sel_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bsc_addr_map.sv
module bsc_addr_map import bsc_pkg::*; #(
    parameter  int unsigned NUM_BANKS = 3,
    parameter  int unsigned BSEL_W    = 2,
    localparam int unsigned ADDR_W    = BSEL_W + WORD_IDX_W
) (
    input  logic                  valid_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [WORD_IDX_W-1:0] word_o,
    output logic                  in_range_o,
    output logic [NUM_BANKS-1:0]  sel_o
);

    localparam logic [BSEL_W:0] BANK_LIMIT = (BSEL_W + 1)'(NUM_BANKS);

    logic [BSEL_W-1:0] bank_idx;

    assign bank_idx   = addr_i[ADDR_W-1 -: BSEL_W];
    assign word_o     = addr_i[WORD_IDX_W-1:0];
    assign in_range_o = ({1'b0, bank_idx} < BANK_LIMIT);

    // One select line per enabled bank; a disabled index raises none.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel_o[b] = valid_i && (bank_idx == BSEL_W'(b));
    end

endmodule

// File: rtl/bsc_bank.sv
module bsc_bank import bsc_pkg::*; #(
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  we_i,
    input  logic [WORD_IDX_W-1:0] waddr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  re_i,
    input  logic [WORD_IDX_W-1:0] raddr_i,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [DATA_W-1:0] mem_q [BANK_DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Read-before-write on a shared word: the read register takes the old word.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/bsc_power_ctrl.sv
module bsc_power_ctrl import bsc_pkg::*; #(
    parameter int unsigned NUM_BANKS    = 3,
    parameter bit          LOW_POWER_EN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] target_i,
    input  logic [NUM_BANKS-1:0] access_i,
    output logic [NUM_BANKS-1:0] awake_o
);

    if (LOW_POWER_EN) begin : g_lp
        pwr_state_e state_d [NUM_BANKS];
        pwr_state_e state_q [NUM_BANKS];

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // A request seen now wakes the bank for the following cycle,
            // which is the cycle the delayed request reaches the array.
            always_comb begin
                state_d[b] = target_i[b] ? PWR_AWAKE : PWR_SLEEP;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q[b] <= PWR_SLEEP;
                end else begin
                    state_q[b] <= state_d[b];
                end
            end

            assign awake_o[b] = (state_q[b] == PWR_AWAKE);

            AST_ACCESS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
                access_i[b] |-> state_q[b] == PWR_AWAKE); // R9
            AST_SLEEP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !access_i[b] |-> state_q[b] == PWR_SLEEP); // R9
        end
    end else begin : g_on
        logic unused_pwr;
        assign unused_pwr = ^{clk, rst_n, target_i, access_i};
        assign awake_o    = '1;
    end

endmodule

// File: rtl/bsc_read_pipe.sv
module bsc_read_pipe #(
    parameter int unsigned DEPTH  = 11,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
    } slot_t;

    slot_t [DEPTH-1:0] pipe_d;
    slot_t [DEPTH-1:0] pipe_q;

    // One slot per outstanding read; a new read may enter every cycle.
    always_comb begin
        pipe_d[0] = '{v: in_valid_i, d: in_data_i};
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid_o = pipe_q[DEPTH-1].v;
    assign out_data_o  = pipe_q[DEPTH-1].d;

endmodule

// File: rtl/banked_sram_channel.sv
module banked_sram_channel import bsc_pkg::*; #(
    parameter  int unsigned NUM_BANKS    = 3,
    parameter  int unsigned DATA_W       = 16,
    parameter  bit          FORWARD_EN   = 1'b1,
    parameter  bit          LOW_POWER_EN = 1'b0,
    localparam int unsigned BSEL_W       = bank_sel_width(NUM_BANKS),
    localparam int unsigned ADDR_W       = BSEL_W + WORD_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 rd_valid_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic                 rd_valid_o,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_BANKS-1:0] bank_awake_o
);

    localparam int unsigned LAT        = read_latency(LOW_POWER_EN);
    // Registers after the array read register; equal in both modes because
    // the wake stage sits in front of the array.
    localparam int unsigned PIPE_DEPTH = CORE_LAT + TAIL_LAT - 1;
    localparam int unsigned CNT_W      = $clog2(LAT + 1);

    if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS || DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_cfg
        $error("banked_sram_channel: NUM_BANKS or DATA_W out of range");
    end

    typedef struct packed {
        logic                  rd_v;
        logic                  rd_ok;
        logic [NUM_BANKS-1:0]  rd_sel;
        logic [WORD_IDX_W-1:0] rd_word;
        logic                  wr_v;
        logic                  wr_ok;
        logic [NUM_BANKS-1:0]  wr_sel;
        logic [WORD_IDX_W-1:0] wr_word;
        logic [DATA_W-1:0]     wr_data;
        logic                  fwd;
    } req_t;

    typedef struct packed {
        logic                 v;
        logic                 ok;
        logic [NUM_BANKS-1:0] sel;
        logic                 fwd;
        logic [DATA_W-1:0]    fwd_data;
    } rstage_t;

    // ---------------------------------------------------------------
    // Address decode of both ports
    // ---------------------------------------------------------------
    logic [WORD_IDX_W-1:0] rd_word, wr_word;
    logic                  rd_ok, wr_ok;
    logic [NUM_BANKS-1:0]  rd_sel, wr_sel;

    bsc_addr_map #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_rd_map (
        .valid_i    (rd_valid_i),
        .addr_i     (rd_addr_i),
        .word_o     (rd_word),
        .in_range_o (rd_ok),
        .sel_o      (rd_sel)
    );

    bsc_addr_map #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W)) u_wr_map (
        .valid_i    (wr_valid_i),
        .addr_i     (wr_addr_i),
        .word_o     (wr_word),
        .in_range_o (wr_ok),
        .sel_o      (wr_sel)
    );

    req_t req_in;
    req_t req_acc;

    // The collision is detected at the ports and travels with the request.
    always_comb begin
        req_in         = '0;
        req_in.rd_v    = rd_valid_i;
        req_in.rd_ok   = rd_ok;
        req_in.rd_sel  = rd_sel;
        req_in.rd_word = rd_word;
        req_in.wr_v    = wr_valid_i;
        req_in.wr_ok   = wr_ok;
        req_in.wr_sel  = wr_sel;
        req_in.wr_word = wr_word;
        req_in.wr_data = wr_data_i;
        req_in.fwd     = FORWARD_EN && rd_valid_i && wr_valid_i && wr_ok
                         && (rd_addr_i == wr_addr_i);
    end

    // ---------------------------------------------------------------
    // Wake stage: in light-sleep mode both ports wait one cycle so that
    // the target bank is awake when the request reaches it.
    // ---------------------------------------------------------------
    if (LOW_POWER_EN) begin : g_wake_stage
        req_t wake_d, wake_q;

        always_comb begin
            wake_d = req_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wake_q <= '0;
            end else begin
                wake_q <= wake_d;
            end
        end

        assign req_acc = wake_q;
    end else begin : g_no_wake
        assign req_acc = req_in;
    end

    // ---------------------------------------------------------------
    // Banks
    // ---------------------------------------------------------------
    logic [NUM_BANKS-1:0] bank_we, bank_re;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = req_acc.wr_v && req_acc.wr_sel[b];
        assign bank_re[b] = req_acc.rd_v && req_acc.rd_sel[b];

        bsc_bank #(.DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .we_i    (bank_we[b]),
            .waddr_i (req_acc.wr_word),
            .wdata_i (req_acc.wr_data),
            .re_i    (bank_re[b]),
            .raddr_i (req_acc.rd_word),
            .rdata_o (bank_rdata[b])
        );
    end

    bsc_power_ctrl #(.NUM_BANKS(NUM_BANKS), .LOW_POWER_EN(LOW_POWER_EN)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .target_i (rd_sel | wr_sel),
        .access_i (bank_we | bank_re),
        .awake_o  (bank_awake_o)
    );

    // ---------------------------------------------------------------
    // Read stage, aligned with the bank read registers
    // ---------------------------------------------------------------
    rstage_t rs_d, rs_q;

    always_comb begin
        rs_d          = '0;
        rs_d.v        = req_acc.rd_v;
        rs_d.ok       = req_acc.rd_ok;
        rs_d.sel      = req_acc.rd_sel;
        rs_d.fwd      = req_acc.fwd;
        rs_d.fwd_data = req_acc.wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    logic [DATA_W-1:0] mux_data;

    always_comb begin
        mux_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rs_q.sel[b]) begin
                mux_data |= bank_rdata[b];
            end
        end
        if (!rs_q.ok) begin
            mux_data = '0;
        end
        if (rs_q.fwd) begin
            mux_data = rs_q.fwd_data;
        end
    end

    bsc_read_pipe #(.DEPTH(PIPE_DEPTH), .DATA_W(DATA_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (rs_q.v),
        .in_data_i   (mux_data),
        .out_valid_o (rd_valid_o),
        .out_data_o  (rd_data_o)
    );

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic [CNT_W-1:0] inflight_d, inflight_q;

    always_comb begin
        inflight_d = inflight_q + CNT_W'(rd_valid_i) - CNT_W'(rd_valid_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_d;
        end
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LAT)); // R3
    AST_NO_ORPHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> inflight_q != '0); // R1
    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_acc.wr_v && !req_acc.wr_ok) |-> bank_we == '0); // R8
    AST_FWD_STILL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        req_acc.fwd |-> bank_we != '0); // R5

endmodule

// File: tb/test_banked_sram_channel.sv
module test_banked_sram_channel;

    localparam int unsigned NB    = 3;
    localparam int unsigned DW    = 16;
    localparam int unsigned AW    = 13;
    localparam int unsigned LAT_N = 12;
    localparam int unsigned LAT_L = 13;
    localparam int unsigned SLOTS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          a_v, b_v;
    logic [DW-1:0] a_d, b_d;
    logic [NB-1:0] a_wake, b_wake;

    banked_sram_channel #(.NUM_BANKS(NB), .DATA_W(DW), .FORWARD_EN(1'b1), .LOW_POWER_EN(1'b0))
    i_banked_sram_channel (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
        .rd_valid_o(a_v), .rd_data_o(a_d), .bank_awake_o(a_wake)
    );

    banked_sram_channel #(.NUM_BANKS(NB), .DATA_W(DW), .FORWARD_EN(1'b0), .LOW_POWER_EN(1'b1))
    i_banked_sram_channel_lp (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
        .rd_valid_o(b_v), .rd_data_o(b_d), .bank_awake_o(b_wake)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    bit            ea_v [SLOTS];
    bit            ea_c [SLOTS];
    logic [DW-1:0] ea_d [SLOTS];
    string         ea_t [SLOTS];
    bit            eb_v [SLOTS];
    bit            eb_c [SLOTS];
    logic [DW-1:0] eb_d [SLOTS];
    string         eb_t [SLOTS];
    logic [NB-1:0] eb_w [SLOTS];
    logic [DW-1:0] model [int];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void clear_slots();
        for (int i = 0; i < SLOTS; i++) begin
            ea_v[i] = 1'b0; ea_c[i] = 1'b0; ea_d[i] = '0; ea_t[i] = "";
            eb_v[i] = 1'b0; eb_c[i] = 1'b0; eb_d[i] = '0; eb_t[i] = "";
            eb_w[i] = '0;
        end
    endfunction

    function automatic logic [AW-1:0] mk(int bank, int word);
        return {2'(bank), 11'(word)};
    endfunction

    // Advance one cycle, compare every output against the slot due now.
    task automatic step();
        int s;
        @(negedge clk);
        cyc++;
        s = cyc % SLOTS;
        check(ea_v[s] ? ea_t[s] : "R1 idle", 32'(a_v), 32'(ea_v[s]));
        if (ea_v[s] && ea_c[s]) check(ea_t[s], 32'(a_d), 32'(ea_d[s]));
        check(eb_v[s] ? eb_t[s] : "R2 idle", 32'(b_v), 32'(eb_v[s]));
        if (eb_v[s] && eb_c[s]) check(eb_t[s], 32'(b_d), 32'(eb_d[s]));
        check("R9 sleep flags", 32'(b_wake), 32'(eb_w[s]));
        check("R9 flags without sleep", 32'(a_wake), 32'(3'b111));
        ea_v[s] = 1'b0; ea_c[s] = 1'b0; eb_v[s] = 1'b0; eb_c[s] = 1'b0; eb_w[s] = '0;
        wr_valid = 1'b0;
        rd_valid = 1'b0;
    endtask

    // Drive one cycle of stimulus and schedule its expected results.
    task automatic drive(bit do_wr, logic [AW-1:0] wa, logic [DW-1:0] wd,
                         bit do_rd, logic [AW-1:0] ra, string tag);
        int sa, sb, sw;
        bit wok, rok;
        logic [DW-1:0] old;
        sa  = (cyc + LAT_N) % SLOTS;
        sb  = (cyc + LAT_L) % SLOTS;
        sw  = (cyc + 1) % SLOTS;
        wok = (int'(wa[12:11]) < NB);
        rok = (int'(ra[12:11]) < NB);
        if (do_rd) begin
            old = model.exists(int'(ra)) ? model[int'(ra)] : '0;
            ea_v[sa] = 1'b1; ea_c[sa] = rok; ea_t[sa] = {tag, " R1"};
            ea_d[sa] = (do_wr && wok && wa == ra) ? wd : old;
            eb_v[sb] = 1'b1; eb_c[sb] = rok; eb_t[sb] = {tag, " R2"};
            eb_d[sb] = old;
            rd_valid = 1'b1;
            rd_addr  = ra;
            if (rok) eb_w[sw][ra[12:11]] = 1'b1;
        end
        if (do_wr) begin
            wr_valid = 1'b1;
            wr_addr  = wa;
            wr_data  = wd;
            if (wok) begin
                model[int'(wa)] = wd;
                eb_w[sw][wa[12:11]] = 1'b1;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic test_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 valid in reset", 32'(a_v), 0);
            check("R11 valid in reset (sleep build)", 32'(b_v), 0);
            check("R11 flags asleep in reset", 32'(b_wake), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic test_write_read();
        drive(1, mk(0, 5), 16'h1111, 0, '0, "R4");
        step();
        drive(0, '0, '0, 1, mk(0, 5), "R4 next-cycle read");
        step();
        drive(1, mk(2, 2047), 16'h2222, 0, '0, "R4");
        idle(3);
        drive(0, '0, '0, 1, mk(2, 2047), "R4 top word");
        idle(15);
    endtask

    task automatic test_banks();
        drive(1, mk(0, 'h123), 16'hA000, 0, '0, "R7"); step();
        drive(1, mk(1, 'h123), 16'hA001, 0, '0, "R7"); step();
        drive(1, mk(2, 'h123), 16'hA002, 0, '0, "R7"); step();
        for (int b = 0; b < 3; b++) begin
            drive(0, '0, '0, 1, mk(b, 'h123), "R7 bank separation");
            step();
        end
        idle(15);
    endtask

    task automatic test_stream();
        for (int i = 0; i < 6; i++) begin
            drive(1, mk(i % 3, 'h300 + i), 16'(16'h5000 + i * 16'h0111), 0, '0, "R3");
            step();
        end
        for (int i = 0; i < 6; i++) begin
            drive(0, '0, '0, 1, mk(i % 3, 'h300 + i), "R3 back-to-back");
            step();
        end
        // Read and write to different words in one cycle.
        drive(1, mk(1, 'h010), 16'h7777, 1, mk(0, 'h300), "R3 mixed");
        step();
        idle(15);
    endtask

    task automatic test_collision();
        drive(1, mk(1, 'h0AB), 16'h00AB, 0, '0, "R5 R6");
        idle(2);
        drive(1, mk(1, 'h0AB), 16'hBEEF, 1, mk(1, 'h0AB), "R5 R6 collision");
        step();
        drive(0, '0, '0, 1, mk(1, 'h0AB), "R5 R6 stored after collision");
        step();
        idle(15);
    endtask

    task automatic test_disabled();
        drive(1, mk(0, 'h040), 16'h4040, 0, '0, "R8"); step();
        drive(1, mk(3, 'h040), 16'hDEAD, 0, '0, "R8 disabled write"); step();
        drive(0, '0, '0, 1, mk(0, 'h040), "R8 enabled bank untouched"); step();
        drive(0, '0, '0, 1, mk(3, 'h040), "R8 disabled read valid"); step();
        for (int b = 1; b < 3; b++) begin
            drive(1, mk(b, 'h040), 16'(16'h0C00 + b), 0, '0, "R8"); step();
        end
        drive(1, mk(3, 'h040), 16'hFACE, 1, mk(2, 'h040), "R8 banks 1-2 untouched"); step();
        drive(0, '0, '0, 1, mk(1, 'h040), "R8 bank 1 untouched"); step();
        idle(15);
    endtask

    task automatic test_sleep();
        drive(1, mk(2, 'h777), 16'h5EE9, 0, '0, "R10");
        idle(25);
        drive(0, '0, '0, 1, mk(2, 'h777), "R10 after long sleep"); step();
        drive(0, '0, '0, 1, mk(0, 5), "R10 after long sleep"); step();
        idle(15);
    endtask

    task automatic test_reset_midflight();
        drive(0, '0, '0, 1, mk(0, 5), "R11");
        idle(4);
        rst_n = 1'b0;
        clear_slots();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 in-flight read dropped", 32'(a_v), 0);
            check("R11 in-flight read dropped (sleep build)", 32'(b_v), 0);
            check("R11 flags asleep in reset", 32'(b_wake), 0);
        end
        rst_n = 1'b1;
        idle(15);
        drive(0, '0, '0, 1, mk(0, 5), "R11 contents kept"); step();
        idle(15);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        clear_slots();
        test_reset();
        test_write_read();
        test_banks();
        test_stream();
        test_collision();
        test_disabled();
        test_sleep();
        test_reset_midflight();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule